// File: doc/BRIEF.md
# Digit-Serial Decimal Register Adder

This block adds or subtracts two decimal register words one 4-bit digit per clock. Each word holds sixteen digits. The first digit is a base-16 decimal-point position. The next fourteen are BCD magnitude digits, least significant first. The last is a sign digit. The surrounding datapath presents one digit of each operand per cycle on `a_digit_i` and `b_digit_i` and raises `valid_i`. It marks the first digit of a word with `start_i`, and samples the mode on `sub_i` in that same cycle.

Each magnitude digit goes through a 4-bit binary adder with decimal correction. A tens-carry flip-flop joins successive digits. Subtraction adds the nines complement of operand B to operand A with the carry preset to one. The decimal-point digit and the sign digit do not take the correction path: the block passes operand A's digit through unchanged.

Every result digit comes with a flag that says whether it is zero. At the end of the word the block reports whether all fourteen magnitude digits were zero, and whether the top magnitude digit produced an out-of-range carry. Aligning decimal points, handling signs and sequencing passes are left to the controller.

Top module: `bcd_serial_adder`

## Requirements
- R1: Each accepted input digit produces exactly one result digit on `sum_digit_o`, with `sum_valid_o` high, in the clock cycle after the edge that accepts it.
- R2: In add mode, magnitude digit result = (a + b + carry) mod 10, and the new carry is 1 when a + b + carry > 9. Every magnitude result lies in 0..9 for BCD operands.
- R3: The digit accepted with `start_i` loads the carry flag with the mode: 0 for add, 1 for subtract. After each result digit, `carry_o` shows the current carry flag.
- R4: In subtract mode (`sub_i` = 1 at start), magnitude digit result = (a + (9 - b) + carry) mod 10, and the new carry is 1 when that sum exceeds 9.
- R5: `zero_o` is high exactly when the most recent result digit equals 0.
- R6: The slot order within a word is fixed. Slot 0 (the start digit) is the decimal-point digit, slots 1..14 are magnitude digits, and slot 15 is the sign digit. Slots 0 and 15 output operand A's digit unchanged, with any value 0..15. Slot 15 leaves the carry unchanged.
- R7: `overflow_o` is set from slot 14. In add mode it takes that slot's carry-out, and in subtract mode the inverse of that carry-out (a borrow). It holds until the next start.
- R8: `done_o` is high together with the result of slot 15. In that cycle `all_zero_o` is high exactly when all fourteen magnitude results of the word were 0.
- R9: A `valid_i` digit without `start_i`, when no word is open, is ignored and produces no result. A `start_i` in the middle of a word restarts at slot 0.
- R10: The mode is latched at start. Changes on `sub_i` during the rest of the word have no effect.
- R11: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A digit pair is present |
| start_i | input | 1 | First digit (decimal-point slot) of a word |
| sub_i | input | 1 | 1 = subtract, 0 = add; sampled with start |
| a_digit_i | input | 4 | Operand A digit |
| b_digit_i | input | 4 | Operand B digit |
| sum_digit_o | output | 4 | Result digit |
| sum_valid_o | output | 1 | Result digit is valid |
| carry_o | output | 1 | Tens-carry flag |
| zero_o | output | 1 | Latest result digit is zero |
| done_o | output | 1 | Result of the sign slot, end of word |
| all_zero_o | output | 1 | All magnitude results of the word were zero |
| overflow_o | output | 1 | Carry or borrow out of the top magnitude digit |

## Verification
A zero result digit and a carry-out can occur on the same digit, for example 5 + 5 or a nines-complement difference of equal digits. The zero flag must then be high while the carry flag is also set. The bench provokes this with words that sum to exactly one hundred trillion and with equal operands in subtract mode. In both cases every magnitude digit is zero and the carry ripples through all of them. The scoreboard compares the digit, the zero flag and the carry on every cycle, and checks at the end of the word that both all-zero and the top-digit overflow or borrow come out correctly.

// File: rtl/bcd_adder_pkg.sv
package bcd_adder_pkg;
  localparam int unsigned DIGIT_W = 4;

  typedef enum logic [1:0] {
    SLOT_POINT = 2'd0,
    SLOT_MAG   = 2'd1,
    SLOT_SIGN  = 2'd2
  } slot_e;
endpackage

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
  import bcd_adder_pkg::*;
(
  input  logic [DIGIT_W-1:0] a_i,
  input  logic [DIGIT_W-1:0] b_i,
  input  logic               carry_i,
  input  logic               sub_i,
  output logic [DIGIT_W-1:0] sum_o,
  output logic               carry_o
);
  logic [DIGIT_W-1:0] b_eff;
  logic [DIGIT_W:0]   raw;

  always_comb begin
    b_eff   = sub_i ? (4'd9 - b_i) : b_i;
    raw     = {1'b0, a_i} + {1'b0, b_eff} + {{DIGIT_W{1'b0}}, carry_i};
    carry_o = (raw > 5'd9);
    // +6 skips the six unused codes; the low nibble is the decimal digit
    sum_o   = carry_o ? (raw[DIGIT_W-1:0] + 4'd6) : raw[DIGIT_W-1:0];
  end
endmodule

// File: rtl/digit_slot_tracker.sv
module digit_slot_tracker
  import bcd_adder_pkg::*;
#(
  parameter int unsigned NUM_MAG = 14
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  logic  start_i,
  output logic  accept_o,
  output slot_e slot_o,
  output logic  top_mag_o,
  output logic  last_o,
  output logic  active_o
);
  localparam int unsigned SLOTS = NUM_MAG + 2;
  localparam int unsigned POS_W = $clog2(SLOTS);

  logic [POS_W-1:0] pos_q, pos;
  logic             active_q;

  always_comb begin
    pos       = start_i ? '0 : pos_q;
    accept_o  = valid_i && (start_i || active_q);
    top_mag_o = (pos == POS_W'(NUM_MAG));
    last_o    = (pos == POS_W'(SLOTS - 1));
    if (pos == '0)   slot_o = SLOT_POINT;
    else if (last_o) slot_o = SLOT_SIGN;
    else             slot_o = SLOT_MAG;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      active_q <= 1'b0;
    end else if (accept_o) begin
      pos_q    <= pos + 1'b1;
      active_q <= !last_o;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/bcd_serial_adder.sv
module bcd_serial_adder
  import bcd_adder_pkg::*;
#(
  parameter int unsigned NUM_MAG = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               start_i,
  input  logic               sub_i,
  input  logic [DIGIT_W-1:0] a_digit_i,
  input  logic [DIGIT_W-1:0] b_digit_i,
  output logic [DIGIT_W-1:0] sum_digit_o,
  output logic               sum_valid_o,
  output logic               carry_o,
  output logic               zero_o,
  output logic               done_o,
  output logic               all_zero_o,
  output logic               overflow_o
);
  logic               accept, top_mag, last, active_w;
  slot_e              slot;
  logic               mode;
  logic [DIGIT_W-1:0] add_sum, result;
  logic               add_cout;

  logic               sub_q, carry_q, valid_q, zero_q, done_q, allz_q, ovf_q;
  logic [DIGIT_W-1:0] sum_q;

  digit_slot_tracker #(.NUM_MAG(NUM_MAG)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .start_i   (start_i),
    .accept_o  (accept),
    .slot_o    (slot),
    .top_mag_o (top_mag),
    .last_o    (last),
    .active_o  (active_w)
  );

  assign mode = start_i ? sub_i : sub_q;

  bcd_digit_adder u_add (
    .a_i     (a_digit_i),
    .b_i     (b_digit_i),
    .carry_i (carry_q),
    .sub_i   (mode),
    .sum_o   (add_sum),
    .carry_o (add_cout)
  );

  assign result = (slot == SLOT_MAG) ? add_sum : a_digit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q   <= 1'b0;
      carry_q <= 1'b0;
      valid_q <= 1'b0;
      zero_q  <= 1'b0;
      done_q  <= 1'b0;
      allz_q  <= 1'b0;
      ovf_q   <= 1'b0;
      sum_q   <= '0;
    end else begin
      valid_q <= accept;
      done_q  <= accept && last;
      if (accept) begin
        sum_q  <= result;
        zero_q <= (result == '0);
        unique case (slot)
          SLOT_POINT: begin
            sub_q   <= sub_i;
            carry_q <= sub_i;  // carry-in of one for nines complement
            allz_q  <= 1'b1;
            ovf_q   <= 1'b0;
          end
          SLOT_MAG: begin
            carry_q <= add_cout;
            allz_q  <= allz_q && (add_sum == '0);
            if (top_mag) ovf_q <= mode ? !add_cout : add_cout;
          end
          default: ;
        endcase
      end
    end
  end

  assign sum_digit_o = sum_q;
  assign sum_valid_o = valid_q;
  assign carry_o     = carry_q;
  assign zero_o      = zero_q;
  assign done_o      = done_q;
  assign all_zero_o  = allz_q;
  assign overflow_o  = ovf_q;
endmodule

// File: rtl/bcd_serial_adder_checker.sv
module bcd_serial_adder_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       start_i,
  input logic       sub_i,
  input logic       active_i,
  input logic [3:0] sum_digit_o,
  input logic       sum_valid_o,
  input logic       carry_o,
  input logic       zero_o,
  input logic       done_o
);
  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_valid_o |-> $past(valid_i));

  p_start_carry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && start_i) |=> (carry_o == $past(sub_i)));

  p_zero_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_valid_o |-> (zero_o == (sum_digit_o == 4'd0)));

  p_done_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sum_valid_o);

  p_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !start_i && !active_i) |=> !sum_valid_o);

  always_comb begin
    if (!rst_ni) p_reset_quiet_r11: assert (!sum_valid_o && !done_o);
  end
endmodule

bind bcd_serial_adder bcd_serial_adder_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .start_i     (start_i),
  .sub_i       (sub_i),
  .active_i    (active_w),
  .sum_digit_o (sum_digit_o),
  .sum_valid_o (sum_valid_o),
  .carry_o     (carry_o),
  .zero_o      (zero_o),
  .done_o      (done_o)
);

// File: tb/tb_bcd_serial_adder.sv
module tb_bcd_serial_adder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0, start = 1'b0, sub = 1'b0;
  logic [3:0] a_d = '0, b_d = '0;
  logic [3:0] sum_d;
  logic       sum_v, carry, zero, done, allz, ovf;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [3:0] digit;
    logic       zero;
    logic       carry;
    logic       done;
    logic       allz;
    logic       ovf;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  bcd_serial_adder dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .start_i(start), .sub_i(sub),
    .a_digit_i(a_d), .b_digit_i(b_d), .sum_digit_o(sum_d), .sum_valid_o(sum_v),
    .carry_o(carry), .zero_o(zero), .done_o(done), .all_zero_o(allz), .overflow_o(ovf)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: pop and compare as results appear
  always @(negedge clk) begin
    if (rst_n && sum_v) begin
      if (sb.size() == 0) begin
        check("R9 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " digit"}, sum_d, e.digit);
        check("R5 zero flag", zero, e.zero);
        check("R3 carry", carry, e.carry);
        check("R8 done", done, e.done);
        if (e.done) begin
          check("R8 all zero", allz, e.allz);
          check("R7 overflow", ovf, e.ovf);
        end
      end
    end
  end

  // Driver: ndig digits of a word, model pushed into the scoreboard
  task automatic run_pass(input longint av, input longint bv,
                          input logic [3:0] a_pt, input logic [3:0] a_sg,
                          input bit do_sub, input int ndig, input bit flip_mode,
                          input string mtag);
    longint ra = av, rb = bv;
    bit     c = do_sub, az = 1'b1, ov = 1'b0;
    for (int p = 0; p < ndig; p++) begin
      exp_t e;
      int   ad, bd, t;
      @(negedge clk);
      valid = 1'b1;
      start = (p == 0);
      sub   = (p == 0) ? do_sub : (flip_mode ? !do_sub : do_sub);
      if (p == 0) begin
        a_d = a_pt; b_d = 4'd7;
        e.digit = a_pt; e.tag = "R6 point";
      end else if (p == 15) begin
        a_d = a_sg; b_d = 4'd1;
        e.digit = a_sg; e.tag = "R6 sign";
      end else begin
        ad = int'(ra % 10); bd = int'(rb % 10);
        ra = ra / 10; rb = rb / 10;
        a_d = 4'(ad); b_d = 4'(bd);
        t = ad + (do_sub ? 9 - bd : bd) + int'(c);
        c = (t > 9);
        if (t > 9) t = t - 10;
        e.digit = 4'(t);
        if (t != 0) az = 1'b0;
        if (p == 14) ov = do_sub ? !c : c;
        e.tag = mtag;
      end
      e.zero = (e.digit == 4'd0);
      e.carry = c;
      e.done = (p == 15);
      e.allz = az;
      e.ovf = ov;
      sb.push_back(e);
    end
    @(negedge clk);
    valid = 1'b0; start = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    check("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    #12;
    // R11: outputs quiet during reset
    check("R11 valid", sum_v, 0);
    check("R11 digit", sum_d, 0);
    check("R11 carry", carry, 0);
    check("R11 done", done, 0);
    check("R11 flags", {zero, allz, ovf}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2/R1: plain add with overflow out of the top digit
    run_pass(64'd12345678901234, 64'd98765432109876, 4'd3, 4'd0, 1'b0, 16, 1'b0, "R2 add");
    // R2: carry ripples through every digit, all zero plus overflow
    run_pass(64'd55555555555555, 64'd44444444444445, 4'd15, 4'd9, 1'b0, 16, 1'b0, "R2 ripple");
    // R4: equal operands subtract to zero, no borrow
    run_pass(64'd31415926535897, 64'd31415926535897, 4'd12, 4'd1, 1'b1, 16, 1'b0, "R4 equal");
    // R4/R7: smaller minus larger gives a borrow
    run_pass(64'd5, 64'd7, 4'd0, 4'd0, 1'b1, 16, 1'b0, "R4 borrow");
    // R2: zero plus zero
    run_pass(64'd0, 64'd0, 4'd0, 4'd0, 1'b0, 16, 1'b0, "R2 zeros");
    // R10: sub_i toggled after start
    run_pass(64'd90000000000001, 64'd1, 4'd4, 4'd8, 1'b1, 16, 1'b1, "R10 mode held");
    run_pass(64'd99999999999999, 64'd1, 4'd4, 4'd8, 1'b0, 16, 1'b1, "R10 mode held");

    // R9: stray digit with no open word
    @(negedge clk);
    valid = 1'b1; start = 1'b0; a_d = 4'd5; b_d = 4'd5;
    @(negedge clk);
    valid = 1'b0;
    check("R9 ignored digit", sum_v, 0);

    // R9: restart mid-word
    run_pass(64'd77777, 64'd22222, 4'd2, 4'd0, 1'b0, 6, 1'b0, "R9 partial");
    run_pass(64'd246813579, 64'd111111111, 4'd6, 4'd3, 1'b1, 16, 1'b0, "R9 restart");

    repeat (4) @(negedge clk);
    check("R1 scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule